// File: doc/BRIEF.md
# Asynchronous DRAM access sequencer

This block sits on the controller side of an asynchronous DRAM. It accepts one host request at a time. A request carries a command (read, write or read-modify-write), a packed row/column address and write data. The block turns the request into one complete strobe sequence on the memory pins. It drives the row and then the column on a single shared address bus. It lowers the row strobe, then the column strobe, and sets write-enable and output-enable around them. It ends the sequence by returning both strobes high and holding the precharge gap. Every timing gap is a parameter counted in clock cycles. The block derives the length of each phase from those parameters at elaboration time.

Requests use a valid/ready handshake. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. The host must hold its request stable until the transfer happens. Any request presented while `req_ready` is low is ignored. The response carries no back-pressure. `rsp_valid` is high for one clock per finished access, and the host must take `rsp_rdata` in that cycle. The data bus is split into `dq_o`, `dq_oe` and `dq_i`, and the tristate pad sits outside the block. Each access uses exactly one column strobe inside one row strobe.

Top module: `dram_seq`

## Requirements
- R1: After reset, ras_n, cas_n, we_n and oe_n are high, dq_oe is low, rsp_valid is low and req_ready is high.
- R2: The row (req_addr upper ROW_W bits) is on dram_addr for at least T_ASR cycles before ras_n falls and is held for T_RAH cycles after. The column (lower COL_W bits) is then on dram_addr for at least T_ASC cycles before cas_n falls and is held for T_CAH cycles after.
- R3: ras_n stays low for at least T_RAS cycles. Between accesses it stays high for at least T_RP cycles. cas_n is high for at least T_CRP cycles before ras_n falls, and it is high when ras_n rises.
- R4: cas_n falls exactly once per ras_n low period, only while ras_n is low, and then stays low for at least T_CAS cycles.
- R5: The level of we_n when cas_n falls selects the operation: low for command 2'b01 (write), high for 2'b00 (read), 2'b10 (read-modify-write) and 2'b11 (the reserved code, which is handled as a read).
- R6: For a write, dq_oe is high with the write data at least T_DS cycles before cas_n falls, and the data is held for T_DH cycles after. we_n stays low for at least T_WP cycles.
- R7: For a read, oe_n is low only while cas_n is low and we_n is high. The data is captured no earlier than T_RAC after the ras_n fall, T_CAC after the cas_n fall, T_OEA after the oe_n fall and T_AA after the column appears. It is returned on rsp_rdata.
- R8: In a read-modify-write, cas_n falls once. The cell is read with we_n high and oe_n low. Then oe_n rises and one cycle passes with the bus undriven. The new data is then driven for T_DS cycles before we_n falls, and we_n stays low for at least max(T_WP, T_DH) cycles. rsp_rdata returns the old value and the cell keeps the new one.
- R9: dq_oe is never high while oe_n is low.
- R10: req_ready is high only when idle. It drops in the cycle after a transfer, and a request held during a busy period is not performed.
- R11: rsp_valid is high for exactly one cycle per accepted request, in the first cycle in which ras_n is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request may transfer |
| req_cmd | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Data for write and read-modify-write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid for reads |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_o | output | DATA_W | Data toward memory |
| dq_oe | output | 1 | Drive enable for dq_o |
| dq_i | input | DATA_W | Data from memory |

## Verification
The bench builds the block with a 3-bit row, a 3-bit column and 8-bit data, so a full model of the 64 cells sits in the bench. The timing set is chosen so that the row-to-data delay, not the column delay, sets the read phase. T_RAS then extends the row strobe past the end of the column phase, and T_DS is longer than T_ASC, so the column setup phase is stretched. With these values, any capture one cycle too early or any shortened strobe leads the memory model to return inverted data or report a timing breach.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_RMW   = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ROWS,
    S_RAH,
    S_COLS,
    S_CASLO,
    S_TURN,
    S_WSET,
    S_WLO,
    S_CASUP,
    S_PRE
  } state_e;

  typedef enum logic [1:0] {
    AS_NONE,
    AS_ROW,
    AS_COL
  } asel_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int atleast1(input int a);
    return (a < 1) ? 1 : a;
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dram_seq_ras_meter.sv
module dram_seq_ras_meter #(
  parameter int T_RAS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic met
);

  localparam int LIM   = (T_RAS < 1) ? 1 : T_RAS;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam logic [CNT_W-1:0] SAT    = CNT_W'(LIM);
  localparam logic [CNT_W-1:0] THRESH = CNT_W'(LIM - 1);

  logic [CNT_W-1:0] cnt;

  // Counts the cycles that ras has already spent low before the current one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!ras_low) begin
      cnt <= '0;
    end else if (cnt != SAT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign met = ras_low && (cnt >= THRESH);

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic [1:0]                    req_cmd,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  input  asel_e                         asel,
  input  logic                          capture,
  input  logic [DATA_W-1:0]             dq_i,
  output cmd_e                          cmd_q,
  output logic [imax(ROW_W,COL_W)-1:0]  dram_addr,
  output logic [DATA_W-1:0]             dq_o,
  output logic [DATA_W-1:0]             rdata
);

  localparam int ADDR_W = imax(ROW_W, COL_W);

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= CMD_READ;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cmd_q   <= cmd_e'(req_cmd);
      row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
      col_q   <= req_addr[COL_W-1:0];
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= dq_i;
    end
  end

  always_comb begin
    unique case (asel)
      AS_ROW:  dram_addr = ADDR_W'(row_q);
      AS_COL:  dram_addr = ADDR_W'(col_q);
      default: dram_addr = '0;
    endcase
  end

  assign dq_o = wdata_q;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 1,
  parameter int T_ASC  = 1,
  parameter int T_CAH  = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3,
  parameter int T_CAS  = 2,
  parameter int T_CRP  = 1,
  parameter int T_DS   = 1,
  parameter int T_DH   = 2,
  parameter int T_WP   = 2,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 3,
  parameter int T_OEA  = 2,
  parameter int T_AA   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_cmd,
  input  logic [ROW_W+COL_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          ras_n,
  output logic                          cas_n,
  output logic                          we_n,
  output logic                          oe_n,
  output logic [imax(ROW_W,COL_W)-1:0]  dram_addr,
  output logic [DATA_W-1:0]             dq_o,
  output logic                          dq_oe,
  input  logic [DATA_W-1:0]             dq_i
);

  localparam int ADDR_W = imax(ROW_W, COL_W);

  // Phase lengths in cycles, each at least one.
  localparam int D_ROWS = atleast1(T_ASR);
  localparam int D_RAH  = atleast1(T_RAH);
  localparam int D_COLS = atleast1(imax(T_ASC, T_DS));
  localparam int D_RD   = atleast1(imax(imax(imax(T_CAS, T_CAH), imax(T_CAC, T_OEA)),
                                        imax(T_AA - D_COLS, T_RAC - D_RAH - D_COLS)));
  localparam int D_WR   = atleast1(imax(imax(T_CAS, T_CAH), imax(T_DH, T_WP)));
  localparam int D_WSET = atleast1(T_DS);
  localparam int D_WLO  = atleast1(imax(T_WP, T_DH));
  localparam int D_PRE  = atleast1(imax(T_RP, T_CRP));
  localparam int D_MAX  = imax(imax(imax(D_ROWS, D_RAH), imax(D_COLS, D_RD)),
                               imax(imax(D_WR, D_WSET), imax(D_WLO, D_PRE)));
  localparam int TMR_W  = imax(1, $clog2(D_MAX + 1));

  state_e state, nxt;
  cmd_e   cmd_q;
  asel_e  asel;
  logic   tmr_expired;
  logic   tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic   ras_low;
  logic   ras_met;
  logic   accept;
  logic   capture;
  logic   is_write;
  logic   is_rmw;
  logic   rsp_q;

  assign is_write = (cmd_q == CMD_WRITE);
  assign is_rmw   = (cmd_q == CMD_RMW);
  assign accept   = (state == S_IDLE) && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      state <= nxt;
    end
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (req_valid)   nxt = S_ROWS;
      S_ROWS:  if (tmr_expired) nxt = S_RAH;
      S_RAH:   if (tmr_expired) nxt = S_COLS;
      S_COLS:  if (tmr_expired) nxt = S_CASLO;
      S_CASLO: if (tmr_expired) nxt = is_rmw ? S_TURN : S_CASUP;
      S_TURN:  if (tmr_expired) nxt = S_WSET;
      S_WSET:  if (tmr_expired) nxt = S_WLO;
      S_WLO:   if (tmr_expired) nxt = S_CASUP;
      S_CASUP: if (ras_met)     nxt = S_PRE;
      S_PRE:   if (tmr_expired) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      S_ROWS:  tmr_val = TMR_W'(D_ROWS - 1);
      S_RAH:   tmr_val = TMR_W'(D_RAH - 1);
      S_COLS:  tmr_val = TMR_W'(D_COLS - 1);
      S_CASLO: tmr_val = is_write ? TMR_W'(D_WR - 1) : TMR_W'(D_RD - 1);
      S_WSET:  tmr_val = TMR_W'(D_WSET - 1);
      S_WLO:   tmr_val = TMR_W'(D_WLO - 1);
      S_PRE:   tmr_val = TMR_W'(D_PRE - 1);
      default: tmr_val = '0;
    endcase
  end

  assign tmr_load = (nxt != state);

  dram_seq_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign ras_low = !((state == S_IDLE) || (state == S_ROWS) || (state == S_PRE));

  dram_seq_ras_meter #(
    .T_RAS (T_RAS)
  ) u_ras_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_low (ras_low),
    .met     (ras_met)
  );

  always_comb begin
    unique case (state)
      S_ROWS, S_RAH:                               asel = AS_ROW;
      S_COLS, S_CASLO, S_TURN, S_WSET, S_WLO, S_CASUP: asel = AS_COL;
      default:                                     asel = AS_NONE;
    endcase
  end

  assign capture = (state == S_CASLO) && tmr_expired && !is_write;

  dram_seq_dpath #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_cmd   (req_cmd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .asel      (asel),
    .capture   (capture),
    .dq_i      (dq_i),
    .cmd_q     (cmd_q),
    .dram_addr (dram_addr),
    .dq_o      (dq_o),
    .rdata     (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= (state == S_CASUP) && ras_met;
    end
  end

  assign rsp_valid = rsp_q;
  assign req_ready = (state == S_IDLE);
  assign ras_n     = !ras_low;
  assign cas_n     = !((state == S_CASLO) || (state == S_TURN) ||
                       (state == S_WSET)  || (state == S_WLO));
  assign we_n      = !((is_write && ((state == S_COLS) || (state == S_CASLO))) ||
                       (state == S_WLO));
  assign oe_n      = !((state == S_CASLO) && !is_write);
  assign dq_oe     = (is_write && ((state == S_COLS) || (state == S_CASLO))) ||
                     (state == S_WSET) || (state == S_WLO);

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] dram_addr,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && cas_n && we_n && oe_n && !dq_oe));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_at_ras_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> rsp_valid);

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_row_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));

  p_col_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(dram_addr));

  p_write_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> (dq_oe && $stable(dq_o)));

  p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_n && we_n));

  p_cas_high_at_ras_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

endmodule

bind dram_seq dram_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .dram_addr (dram_addr),
  .dq_o      (dq_o),
  .dq_oe     (dq_oe)
);

// File: tb/test_dram_seq.sv
`timescale 1ns/1ps
module test_dram_seq;

  localparam int ROW_W  = 3;
  localparam int COL_W  = 3;
  localparam int DATA_W = 8;
  localparam int AW     = 3;
  localparam int T_ASR  = 2;
  localparam int T_RAH  = 2;
  localparam int T_ASC  = 1;
  localparam int T_CAH  = 2;
  localparam int T_RAS  = 9;
  localparam int T_RP   = 3;
  localparam int T_CAS  = 2;
  localparam int T_CRP  = 2;
  localparam int T_DS   = 2;
  localparam int T_DH   = 2;
  localparam int T_WP   = 3;
  localparam int T_RAC  = 8;
  localparam int T_CAC  = 3;
  localparam int T_OEA  = 2;
  localparam int T_AA   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_cmd = 2'b00;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_rdata;
  logic ras_n, cas_n, we_n, oe_n;
  logic [AW-1:0] dram_addr;
  logic [7:0] dq_o;
  logic dq_oe;
  logic [7:0] dq_i;

  always #2 clk = ~clk;

  dram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CAH(T_CAH),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS), .T_CRP(T_CRP),
    .T_DS(T_DS), .T_DH(T_DH), .T_WP(T_WP), .T_RAC(T_RAC),
    .T_CAC(T_CAC), .T_OEA(T_OEA), .T_AA(T_AA)
  ) i_dram_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dram_addr(dram_addr), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_iss = 0;
  int n_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Scoreboard items
  typedef struct packed {
    logic       is_rd;
    logic [7:0] data;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] mir [0:63];
  logic [1:0] cur_cmd = 2'b00;

  // Memory model with timing checks, sampled on falling edges
  logic [7:0] mem [0:63];
  logic p_ras, p_cas, p_we;
  logic [AW-1:0] p_addr;
  int ras_lo, ras_hi, cas_lo, cas_hi, we_lo, oe_lo, dqoe_run, addr_run;
  int asu, dsu;
  bit seen_ras, wr_op;
  int cas_falls;
  logic [2:0] row_l, col_l;
  logic [7:0] wd_l;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 5) & 8'hff);
      p_ras = 1; p_cas = 1; p_we = 1; p_addr = '0;
      ras_lo = 0; ras_hi = 100; cas_lo = 0; cas_hi = 100; we_lo = 0; oe_lo = 0;
      dqoe_run = 0; addr_run = 0; seen_ras = 0; wr_op = 0; cas_falls = 0;
      row_l = '0; col_l = '0; wd_l = '0; dq_i = '0;
    end else begin
      asu = (dram_addr == p_addr) ? addr_run : 0;
      dsu = dqoe_run;
      if (p_ras && !ras_n) begin
        if (seen_ras) chk(ras_hi >= T_RP, "R3", "ras high gap", ras_hi, T_RP);
        chk(cas_hi >= T_CRP, "R3", "cas high before ras fall", cas_hi, T_CRP);
        chk(asu >= T_ASR, "R2", "row setup", asu, T_ASR);
        row_l = dram_addr; cas_falls = 0; seen_ras = 1; wr_op = 0;
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo >= T_RAS, "R3", "ras low width", ras_lo, T_RAS);
        chk(cas_n, "R3", "cas high at ras rise", cas_n, 1);
      end
      if (p_cas && !cas_n) begin
        chk(!ras_n && cas_falls == 0, "R4", "single cas fall in ras", cas_falls, 0);
        cas_falls++;
        chk(asu >= T_ASC, "R2", "column setup", asu, T_ASC);
        col_l = dram_addr;
        wr_op = !we_n;
        chk(wr_op == (cur_cmd == 2'b01), "R5", "op at cas fall", wr_op, cur_cmd == 2'b01);
        if (wr_op) begin
          chk(dq_oe && dsu >= T_DS, "R6", "write data setup", dsu, T_DS);
          wd_l = dq_o;
          mem[{row_l, col_l}] = dq_o;
        end
      end
      if (!p_cas && cas_n) chk(cas_lo >= T_CAS, "R4", "cas low width", cas_lo, T_CAS);
      if (p_we && !we_n && !cas_n && !p_cas) begin
        chk(oe_n, "R8", "oe high before we fall", oe_n, 1);
        chk(dq_oe && dsu >= T_DS, "R8", "data setup before we fall", dsu, T_DS);
        wd_l = dq_o; wr_op = 1;
        mem[{row_l, col_l}] = dq_o;
      end
      if (!p_we && we_n) chk(we_lo >= T_WP, "R6", "we low width", we_lo, T_WP);
      if (dq_oe && !oe_n) chk(0, "R9", "bus driven with oe low", 1, 0);

      ras_lo   = ras_n ? 0 : ras_lo + 1;
      ras_hi   = ras_n ? ras_hi + 1 : 0;
      cas_lo   = cas_n ? 0 : cas_lo + 1;
      cas_hi   = cas_n ? cas_hi + 1 : 0;
      we_lo    = we_n ? 0 : we_lo + 1;
      oe_lo    = oe_n ? 0 : oe_lo + 1;
      dqoe_run = dq_oe ? dqoe_run + 1 : 0;
      addr_run = (dram_addr == p_addr) ? addr_run + 1 : 1;

      if (!ras_n && ras_lo <= T_RAH)
        chk(dram_addr == row_l, "R2", "row hold", dram_addr, row_l);
      if (!cas_n && cas_lo <= T_CAH)
        chk(dram_addr == col_l, "R2", "column hold", dram_addr, col_l);
      if (!cas_n && wr_op && cur_cmd == 2'b01 && cas_lo <= T_DH)
        chk(dq_oe && dq_o == wd_l, "R6", "write data hold", dq_o, wd_l);
      if (!cas_n && !we_n && cur_cmd == 2'b10)
        chk(dq_oe && dq_o == wd_l, "R8", "rmw data hold", dq_o, wd_l);

      if (!oe_n && !cas_n && ras_lo >= T_RAC && cas_lo >= T_CAC &&
          oe_lo >= T_OEA && addr_run >= T_AA)
        dq_i = mem[{row_l, col_l}];
      else
        dq_i = ~mem[{row_l, col_l}];

      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = dram_addr;
    end
  end

  // Response monitor
  logic m_prev_ras = 1'b1;
  logic m_prev_rsp = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        exp_t e;
        n_done++;
        chk(!m_prev_rsp, "R11", "done longer than one cycle", m_prev_rsp, 0);
        chk(ras_n && !m_prev_ras, "R11", "done at ras rise", {m_prev_ras, ras_n}, 2'b01);
        if (exp_q.size() == 0) begin
          chk(0, "R11", "done without request", 1, 0);
        end else begin
          e = exp_q.pop_front();
          if (e.is_rd) chk(rsp_rdata == e.data, "R7", "read data", rsp_rdata, e.data);
        end
      end
      m_prev_ras = ras_n;
      m_prev_rsp = rsp_valid;
    end
  end

  // Driver
  task automatic issue(input logic [1:0] cmd, input logic [5:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    case (cmd)
      2'b01: begin e.is_rd = 0; e.data = 8'h00; mir[a] = d; end
      2'b10: begin e.is_rd = 1; e.data = mir[a]; mir[a] = d; end
      default: begin e.is_rd = 1; e.data = mir[a]; end
    endcase
    exp_q.push_back(e);
    cur_cmd = cmd;
    n_iss++;
    @(posedge clk);
    #1;
    req_valid = 0; req_cmd = 2'b01; req_addr = ~a; req_wdata = ~d;
    @(negedge clk);
    chk(!req_ready, "R10", "ready low after transfer", req_ready, 0);
  endtask

  task automatic drain;
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mir[i] = 8'((i * 37 + 5) & 8'hff);
    repeat (4) @(negedge clk);
    // R1: reset levels
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hf);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes idle", {ras_n, cas_n, we_n, oe_n}, 4'hf);
    chk(!dq_oe && !rsp_valid, "R1", "bus and done idle", {dq_oe, rsp_valid}, 0);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    // R6/R5: writes with varied data and the address corners
    issue(2'b01, 6'h00, 8'hA5);
    issue(2'b01, 6'h3F, 8'hFF);
    issue(2'b01, 6'h2A, 8'h00);
    issue(2'b01, 6'h15, 8'h3C);
    // R7: reads back, plus an untouched cell
    issue(2'b00, 6'h00, 8'h00);
    issue(2'b00, 6'h3F, 8'h00);
    issue(2'b00, 6'h2A, 8'h00);
    issue(2'b00, 6'h09, 8'h00);
    // R8: read-modify-write returns old, stores new
    issue(2'b10, 6'h2A, 8'h5C);
    issue(2'b00, 6'h2A, 8'h00);
    issue(2'b10, 6'h3F, 8'h81);
    issue(2'b10, 6'h3F, 8'h7E);
    // R5: reserved code behaves as read
    issue(2'b11, 6'h3F, 8'h11);
    issue(2'b00, 6'h15, 8'h00);

    // R10: a request held while busy is not taken
    issue(2'b00, 6'h07, 8'h00);
    req_valid = 1; req_cmd = 2'b01; req_addr = 6'h07; req_wdata = 8'h33;
    for (int k = 0; k < 5; k++) begin
      chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    drain();
    issue(2'b00, 6'h07, 8'h00);
    drain();

    chk(exp_q.size() == 0, "R11", "responses outstanding", exp_q.size(), 0);
    chk(n_done == n_iss, "R11", "one done per request", n_done, n_iss);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

endmodule